// File: doc/BRIEF.md
# Pipelined SPI ADC Scan Sequencer

This block is an SPI master that sweeps all sixteen inputs of an external serial converter and keeps the latest reading of every input in a register bank. The converter answers each channel-select command two frames late. So every scan sends one command per channel and then two padding frames. The block drops the first two replies and files each later reply under the channel that was selected two frames earlier. It keeps a 10-bit value from every reply.

Scans start from an internal period counter, or at once when `scan_now` pulses. After a trigger, the period restarts from that point. Without a trigger, each deadline is the previous deadline plus one period, so the schedule does not drift. Raising `shut_req` lets the current scan finish, then stops all bus activity for good, so that another device can own the shared bus. The stop is reported on `shut_done`.

Results are read through a valid/ready request channel carrying a channel index, and a valid/ready response channel. A request is accepted when `rd_valid` and `rd_ready` are both high. `rd_ready` is high whenever no response is pending, or the pending response is being taken in the same cycle. A response stays valid, with its data and flag unchanged, until `rsp_ready` is high.

Top module: `adc_scan_seq`

## Requirements
- R1: A scan sends 18 frames. Frames 0 to 15 carry the commands for channels 0 to 15 in ascending order, and frames 16 and 17 repeat the channel-15 command.
- R2: Each 16-bit command is sent MSB first. Bits 12, 11 and 6 are one, bits 10:7 hold the channel number, and every other bit is zero (channel c gives 0x1840 | c<<7).
- R3: `sclk` is low whenever `cs_n` is high. `sclk` runs at the system clock divided by CLK_DIV (8 by default: 4 cycles high, then 4 low). `mosi` changes only on rising `sclk` edges, and `miso` is captured on falling edges.
- R4: `cs_n` rises after every frame. It is low for CLK_DIV/2 + 16·CLK_DIV cycles (132 by default). Between frames of one scan it stays high for GAP_SCLK·CLK_DIV + 1 cycles (505 by default, at least 63 SCLK periods).
- R5: The word received in frame k (k ≥ 2) becomes the result of channel k−2, and frames 0 and 1 are discarded. The stored value is received bits 11:2.
- R6: The readable results change only at the end of a scan, all at once. `scan_done` is a one-cycle pulse in that same cycle.
- R7: Without triggers, consecutive scans begin exactly PERIOD_CYC cycles apart.
- R8: A `scan_now` pulse while idle makes `cs_n` fall on the second clock edge. The next periodic scan then begins PERIOD_CYC cycles after the triggered one.
- R9: When `shut_req` is raised during a scan, that scan completes with valid results. `shut_done` rises one cycle after its `scan_done`, and no further frames are sent.
- R10: A read of index 0..15 returns that channel's value with `rsp_bad` low. An index of 16 or more returns zero with `rsp_bad` high.
- R11: While `rsp_valid` is high and `rsp_ready` is low, the response holds steady and `rd_ready` is low.
- R12: After reset: `cs_n`=1, `sclk`=0, `mosi`=0, `scan_done`=0, `shut_done`=0, `rsp_valid`=0, and all results read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_now | input | 1 | Early-trigger request, one-cycle pulse |
| shut_req | input | 1 | Request to stop scanning after the current scan |
| shut_done | output | 1 | Scanning has stopped for good |
| scan_done | output | 1 | One-cycle pulse when a new bank of results becomes visible |
| sclk | output | 1 | Serial clock to the converter |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Command data to the converter |
| miso | input | 1 | Reply data from the converter |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted |
| rd_ch | input | 5 | Channel index to read |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 10 | Channel value |
| rsp_bad | output | 1 | Index was out of range |

## Verification
The hardest case to reach is checking that each reply is filed under the right channel, because a wrong command order and a wrong realignment can hide each other. The bench therefore uses a converter model that decodes every received command and answers two frames later with a value unique to that channel and scan. It also sets the reply's upper nibble and low two bits to nonzero noise. A result is correct only if the command order, the two-frame offset and the bit extraction are all right. Shutdown is requested in the middle of a scan. The early trigger is fired between two deadlines, so the check can tell a reloaded timer from a drifting one.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int FRAME_W = 16;
  localparam int RES_W   = 10;

  typedef enum logic [1:0] {ENG_IDLE, ENG_SETUP, ENG_SHIFT, ENG_GAP} eng_state_t;

  // Select word: manual mode, doubled range, channel field, fixed bit 6.
  function automatic logic [FRAME_W-1:0] make_cmd(input logic [3:0] ch);
    logic [FRAME_W-1:0] w;
    w = '0;
    w[12]   = 1'b1;
    w[11]   = 1'b1;
    w[10:7] = ch;
    w[6]    = 1'b1;
    return w;
  endfunction

  function automatic logic [RES_W-1:0] take_result(input logic [FRAME_W-1:0] w);
    return w[11:2];
  endfunction
endpackage

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import adc_scan_pkg::*;
#(
  parameter int CLK_DIV  = 8,
  parameter int GAP_SCLK = 63
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] cmd,
  output logic               ready,
  output logic               done,
  output logic [FRAME_W-1:0] rx_word,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi,
  input  logic               miso
);
  localparam int HALF    = CLK_DIV / 2;
  localparam int DW      = $clog2(CLK_DIV);
  localparam int BW      = $clog2(FRAME_W);
  localparam int GAP_CYC = GAP_SCLK * CLK_DIV;
  localparam int GW      = $clog2(GAP_CYC + 1);

  eng_state_t         st;
  logic [DW-1:0]      cnt;
  logic [BW-1:0]      bitn;
  logic [GW-1:0]      gcnt;
  logic [FRAME_W-1:0] sh, rx;

  assign ready = (st == ENG_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ENG_IDLE; cnt <= '0; bitn <= '0; gcnt <= '0;
      sh <= '0; rx <= '0; rx_word <= '0; done <= 1'b0;
      sclk <= 1'b0; cs_n <= 1'b1; mosi <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ENG_IDLE: if (start) begin
          cs_n <= 1'b0; sh <= cmd; cnt <= '0; st <= ENG_SETUP;
        end
        ENG_SETUP: begin
          if (cnt == DW'(HALF - 1)) begin
            cnt <= '0; bitn <= '0; st <= ENG_SHIFT;
          end else cnt <= cnt + 1'b1;
        end
        ENG_SHIFT: begin
          // launch on the rising edge, capture on the falling edge
          if (cnt == '0) begin
            sclk <= 1'b1; mosi <= sh[FRAME_W-1]; sh <= {sh[FRAME_W-2:0], 1'b0};
          end
          if (cnt == DW'(HALF)) begin
            sclk <= 1'b0; rx <= {rx[FRAME_W-2:0], miso};
          end
          if (cnt == DW'(CLK_DIV - 1)) begin
            cnt <= '0;
            if (bitn == BW'(FRAME_W - 1)) begin
              cs_n <= 1'b1; mosi <= 1'b0; done <= 1'b1; rx_word <= rx;
              gcnt <= '0; st <= ENG_GAP;
            end else bitn <= bitn + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        ENG_GAP: begin
          if (gcnt == GW'(GAP_CYC - 1)) st <= ENG_IDLE;
          else gcnt <= gcnt + 1'b1;
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end

  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);
  p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n) $fell(sclk) |-> $stable(mosi));
  p_cs_gap_r4:    assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |=> cs_n);
endmodule

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int PERIOD_CYC = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic early,
  input  logic busy,
  input  logic hold,
  output logic start
);
  localparam int TW = $clog2(PERIOD_CYC);

  logic [TW-1:0] cnt;
  logic          pend, fire, want;

  assign fire  = (cnt == TW'(PERIOD_CYC - 1));
  assign want  = fire | early | pend;
  assign start = want & ~busy & ~hold;

  // Reload on a deadline or a trigger: deadlines stay on a fixed grid.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; pend <= 1'b0;
    end else begin
      cnt  <= (fire | early) ? '0 : cnt + 1'b1;
      pend <= want & ~start;
    end
  end
endmodule

// File: rtl/result_bank.sv
module result_bank
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_ch,
  input  logic [RES_W-1:0] wr_data,
  input  logic             swap,
  input  logic             rd_valid,
  output logic             rd_ready,
  input  logic [CH_W:0]    rd_ch,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [RES_W-1:0] rsp_data,
  output logic             rsp_bad
);
  logic [RES_W-1:0] bank [2][NUM_CH];
  logic             sel;
  logic             in_range;

  assign rd_ready = ~rsp_valid | rsp_ready;
  assign in_range = (rd_ch < (CH_W+1)'(NUM_CH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int c = 0; c < NUM_CH; c++) bank[b][c] <= '0;
      sel <= 1'b0; rsp_valid <= 1'b0; rsp_data <= '0; rsp_bad <= 1'b0;
    end else begin
      if (wr_en) bank[~sel][wr_ch] <= wr_data;
      if (swap)  sel <= ~sel;
      if (rd_valid && rd_ready) begin
        rsp_valid <= 1'b1;
        rsp_bad   <= ~in_range;
        rsp_data  <= in_range ? bank[sel][rd_ch[CH_W-1:0]] : '0;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_bad));
  p_bad_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_bad |-> rsp_data == '0);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int CLK_DIV    = 8,
  parameter int GAP_SCLK   = 63,
  parameter int PERIOD_CYC = 1000000,
  parameter int NUM_CH     = 16,
  parameter int PAD_FRAMES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scan_now,
  input  logic        shut_req,
  output logic        shut_done,
  output logic        scan_done,
  output logic        sclk,
  output logic        cs_n,
  output logic        mosi,
  input  logic        miso,
  input  logic        rd_valid,
  output logic        rd_ready,
  input  logic [4:0]  rd_ch,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [9:0]  rsp_data,
  output logic        rsp_bad
);
  localparam int NFRAMES = NUM_CH + PAD_FRAMES;
  localparam int FW      = $clog2(NFRAMES);
  localparam int CH_W    = $clog2(NUM_CH);

  logic               busy, scan_start, eng_ready, eng_done, eng_go, last;
  logic [FW-1:0]      idx;
  logic [3:0]         fch;
  logic [FRAME_W-1:0] rx_word;
  logic               wr_en;
  logic [CH_W-1:0]    wr_ch;

  scan_timer #(.PERIOD_CYC(PERIOD_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .early(scan_now), .busy(busy),
    .hold(shut_req | shut_done), .start(scan_start));

  // padding frames repeat the highest channel
  assign fch    = (idx < FW'(NUM_CH)) ? idx[3:0] : 4'(NUM_CH - 1);
  assign eng_go = busy & eng_ready;
  assign last   = (idx == FW'(NFRAMES - 1));
  assign wr_en  = eng_done & (idx >= FW'(PAD_FRAMES));
  assign wr_ch  = CH_W'(idx - FW'(PAD_FRAMES));

  spi_frame_engine #(.CLK_DIV(CLK_DIV), .GAP_SCLK(GAP_SCLK)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(eng_go), .cmd(make_cmd(fch)),
    .ready(eng_ready), .done(eng_done), .rx_word(rx_word),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; idx <= '0; scan_done <= 1'b0; shut_done <= 1'b0;
    end else begin
      scan_done <= 1'b0;
      shut_done <= shut_done | (shut_req & ~busy);
      if (scan_start) begin
        busy <= 1'b1; idx <= '0;
      end else if (eng_done) begin
        if (last) begin
          busy <= 1'b0; scan_done <= 1'b1;
        end else idx <= idx + 1'b1;
      end
    end
  end

  result_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_data(take_result(rx_word)), .swap(eng_done & last),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_ch(rd_ch),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_bad(rsp_bad));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n) scan_done |=> !scan_done);
  p_quiet_stop_r9: assert property (@(posedge clk) disable iff (!rst_n) shut_done |-> cs_n && !busy);
  p_no_start_r9:   assert property (@(posedge clk) disable iff (!rst_n) shut_req |-> !scan_start);
endmodule

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;
  timeunit 1ns; timeprecision 1ps;
  localparam int PERIOD = 14000;

  logic clk = 0, rst_n = 0, scan_now = 0, shut_req = 0, miso = 0;
  logic rd_valid = 0, rsp_ready = 1;
  logic [4:0] rd_ch = 0;
  logic shut_done, scan_done, sclk, cs_n, mosi, rd_ready, rsp_valid, rsp_bad;
  logic [9:0] rsp_data;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  adc_scan_seq #(.PERIOD_CYC(PERIOD)) uut (
    .clk(clk), .rst_n(rst_n), .scan_now(scan_now), .shut_req(shut_req),
    .shut_done(shut_done), .scan_done(scan_done), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_ch(rd_ch), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_bad(rsp_bad));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] val(input int s, input int ch);
    if (ch == 9) return 10'h3FF;
    if (ch == 4) return 10'h000;
    return 10'(ch * 67 + s * 29 + 3);
  endfunction

  // ---------------- converter model + scoreboard driver ----------------
  int fidx = 0, cur_k = -1, scan_no = -1, cs_falls = 0, bitc = 0;
  int pipe0 = 0, pipe1 = 0;
  logic [15:0] tx_word = 0, cap = 0;
  longint t_fall = 0, t_rise = 0, t_sr = 0;
  longint scan_t [8];
  logic [9:0] exp_q [$];

  always @(negedge cs_n) begin
    t_fall = $time;
    if (cs_falls > 0 && cur_k != 17)
      chk((t_fall - t_rise) >= 5040 && (t_fall - t_rise) <= 5060, "R4", "inter-frame gap ns",
          t_fall - t_rise, 5050);
    cur_k = fidx;
    fidx  = (fidx == 17) ? 0 : fidx + 1;
    cs_falls++;
    if (cur_k == 0) begin
      scan_no++;
      if (scan_no < 8) scan_t[scan_no] = $time;
    end
    tx_word = {4'(pipe1), val(scan_no, pipe1), 2'b11};
    if (cur_k >= 2) exp_q.push_back(val(scan_no, cur_k - 2));
    bitc = 0; cap = 0;
    miso = tx_word[15];
  end

  always @(posedge sclk) if (cs_n === 1'b0) begin
    if (bitc > 0) chk($time - t_sr == 80, "R3", "sclk period ns", $time - t_sr, 80);
    t_sr = $time;
  end

  always @(negedge sclk) if (cs_n === 1'b0) begin
    chk($time - t_sr == 40, "R3", "sclk high time ns", $time - t_sr, 40);
    cap = {cap[14:0], mosi};
    bitc++;
    if (bitc < 16) miso = tx_word[15 - bitc];
  end

  always @(posedge cs_n) if (cs_falls > 0) begin
    t_rise = $time;
    chk(t_rise - t_fall == 1320, "R4", "cs low time ns", t_rise - t_fall, 1320);
    chk(bitc == 16, "R2", "bits per frame", bitc, 16);
    chk(cap == (16'h1840 | 16'((cur_k < 16 ? cur_k : 15) << 7)), "R1",
        "command word", cap, 16'h1840 | 16'((cur_k < 16 ? cur_k : 15) << 7));
    pipe1 = pipe0;
    pipe0 = int'(cap[10:7]);
  end

  // ---------------- read helper ----------------
  task automatic do_read(input logic [4:0] c, output logic [9:0] d, output logic bad,
                         output logic got);
    @(negedge clk); rd_valid = 1; rd_ch = c;
    @(negedge clk); rd_valid = 0;
    got = rsp_valid; d = rsp_data; bad = rsp_bad;
  endtask

  // ---------------- monitor: pops and compares ----------------
  int mon_scans = 0;
  logic [9:0] last_v [16];

  initial begin
    logic [9:0] d; logic bad, got;
    forever begin
      do @(negedge clk); while (scan_done !== 1'b1);
      chk(exp_q.size() >= 16, "R5", "expected items queued", exp_q.size(), 16);
      for (int c = 0; c < 16; c++) begin
        logic [9:0] e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 10'h0;
        do_read(5'(c), d, bad, got);
        chk(got && !bad, "R10", "valid index response", {got, bad}, 2);
        chk(d == e, "R5", $sformatf("scan %0d ch %0d", mon_scans, c), d, e);
        last_v[c] = d;
      end
      if (mon_scans == 0) begin
        do_read(5'd16, d, bad, got);
        chk(got && bad && d == 0, "R10", "index 16 -> bad, zero", {got, bad, d}, 12'h800 | 12'h400);
        do_read(5'd31, d, bad, got);
        chk(got && bad && d == 0, "R10", "index 31 -> bad, zero", {got, bad, d}, 12'h800 | 12'h400);
      end
      if (mon_scans == 1) begin
        wait (scan_no == 2 && fidx >= 11);
        do_read(5'd0, d, bad, got);
        chk(d == last_v[0], "R6", "value stable mid-scan", d, last_v[0]);
      end
      if (mon_scans == 2) begin
        logic [9:0] held;
        @(negedge clk); rsp_ready = 0; rd_valid = 1; rd_ch = 5'd3;
        @(negedge clk); rd_ch = 5'd5;
        held = rsp_data;
        chk(rsp_valid && held == last_v[3], "R11", "first response", held, last_v[3]);
        for (int i = 0; i < 4; i++) begin
          chk(rd_ready == 0, "R11", "rd_ready low while stalled", rd_ready, 0);
          @(negedge clk);
          chk(rsp_valid && rsp_data == held, "R11", "response held", rsp_data, held);
        end
        rsp_ready = 1;
        @(negedge clk); rd_valid = 0;
        chk(rsp_valid && rsp_data == last_v[5], "R11", "next response after release",
            rsp_data, last_v[5]);
      end
      mon_scans++;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [9:0] d; logic bad, got;
    longint t_trig; int falls0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n == 1 && sclk == 0 && mosi == 0, "R12", "bus idle after reset", {cs_n, sclk, mosi}, 4);
    chk(scan_done == 0 && shut_done == 0 && rsp_valid == 0 && rd_ready == 1, "R12",
        "flags after reset", {scan_done, shut_done, rsp_valid, rd_ready}, 1);
    do_read(5'd7, d, bad, got);
    chk(got && !bad && d == 0, "R12", "result zero after reset", d, 0);

    wait (scan_no == 2);
    chk(scan_t[1] - scan_t[0] == PERIOD * 10, "R7", "period 0->1 ns", scan_t[1] - scan_t[0], PERIOD * 10);
    chk(scan_t[2] - scan_t[1] == PERIOD * 10, "R7", "period 1->2 ns", scan_t[2] - scan_t[1], PERIOD * 10);

    do @(negedge clk); while (scan_done !== 1'b1);
    repeat (1000) @(negedge clk);
    scan_now = 1; t_trig = $time;
    @(negedge clk); scan_now = 0;
    wait (scan_no == 3);
    chk(scan_t[3] - t_trig == 15, "R8", "trigger to cs fall ns", scan_t[3] - t_trig, 15);
    wait (scan_no == 4);
    chk(scan_t[4] - scan_t[3] == PERIOD * 10, "R8", "period restarted ns", scan_t[4] - scan_t[3], PERIOD * 10);

    wait (fidx >= 6);
    @(negedge clk); shut_req = 1;
    do @(negedge clk); while (scan_done !== 1'b1);
    chk(shut_done == 0 && fidx == 0, "R9", "scan completed before stop", {shut_done, fidx[4:0]}, 0);
    @(negedge clk);
    chk(shut_done == 1, "R9", "shut_done after scan", shut_done, 1);
    falls0 = cs_falls;
    repeat (2 * PERIOD) @(negedge clk);
    chk(cs_falls == falls0, "R9", "no frames after stop", cs_falls, falls0);
    chk(shut_done == 1 && cs_n == 1, "R9", "stop holds", {shut_done, cs_n}, 3);
    wait (mon_scans == 5);
    chk(exp_q.size() == 0, "R5", "queue drained", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule